// File: doc/BRIEF.md
# Indirect Configuration Space Access Bridge

This block lets a requester reach the configuration registers of devices behind a link when the only path to them is a memory-mapped window. Each accepted request carries a bus/device/function number, a register offset, an access size of 1, 2 or 4 bytes, a direction, a link select and, for writes, the write data. The bridge checks the request first. A valid request becomes two accesses on a downstream memory bus. The first is a 64-bit write of a packed address word to the base of the selected link's window. The second is a 32-bit data access at a fixed distance above that base, with byte enables that pick the lanes.

The bridge handles one request at a time. A request that fails the checks never reaches the downstream bus. It is answered at once with a parameter-error status, and a read answered this way returns all ones in the requested width. Each answer is a one-cycle done pulse together with the read data and a 2-bit status.

The control is a six-state machine:
- `S_IDLE`: waits for a request. It moves to `S_ADDR_REQ` for a valid request and to `S_DONE` for a rejected one.
- `S_ADDR_REQ`: offers the address word and moves to `S_ADDR_WAIT` when the bus takes it.
- `S_ADDR_WAIT`: moves to `S_DATA_REQ` when the bus returns its response.
- `S_DATA_REQ`: offers the data access and moves to `S_DATA_WAIT` when the bus takes it.
- `S_DATA_WAIT`: moves to `S_DONE` when the bus returns its response, capturing the read data.
- `S_DONE`: pulses done and returns to `S_IDLE`.

Top module: `cfg_window_bridge`

## Requirements
- R1: A request whose offset is above 0xFFF is answered with status 2'b01 (parameter error) and makes no downstream access.
- R2: A request whose offset is not a multiple of its size is answered with status 2'b01 and makes no downstream access. Any offset is aligned for size 1, an even offset is aligned for size 2, and an offset with bits [1:0] = 0 is aligned for size 4.
- R3: A request whose size is not 1, 2 or 4 is answered with status 2'b01 and makes no downstream access.
- R4: A rejected request returns all ones in its width on `rsp_rdata`, zero-extended: 0xFF for size 1, 0xFFFF for size 2, and 0xFFFFFFFF for size 4 or an invalid size. A valid request is answered with status 2'b00. A valid write returns zero data.
- R5: The address word is 64 bits wide. Its bits are numbered MSB-first, so numbered bit n sits at vector index 63-n. Numbered bit 0 (index 63) is the enable bit and is always 1. Bits 1-3 (status) are 0. Bits 4-11 hold the bus number, which is `req_bdf[15:8]`. Bits 12-16 hold the device number, `req_bdf[7:3]`. Bits 17-19 hold the function number, `req_bdf[2:0]`. Bits 20-31 hold the offset with bits [1:0] cleared. Bit 32 (type) and every bit after it are 0.
- R6: The address word is written with `mem_wide`=1, `mem_write`=1 and `mem_be`=0xFF, to window base = `BASE_ADDR` + link × 256.
- R7: The data access uses `mem_wide`=0, address = window base + 128, and `mem_write` equal to the request direction. Byte lane k is data bits [8k+7:8k] (little-endian). Size 1 enables lane `offset[1:0]`. Size 2 enables lanes 2·`offset[1]` and 2·`offset[1]`+1. Size 4 enables all four lanes. Write data is shifted into the enabled lanes, and the access stays on the bus unchanged until accepted.
- R8: The data access is not offered before the downstream response to the address write has been returned.
- R9: A valid read returns the enabled lanes of the data response, shifted down to bit 0 and zero-extended.
- R10: After reset `req_ready` is 1 and `rsp_done` and `mem_valid` are 0. `req_ready` is 0 from acceptance until the done pulse, which lasts one cycle. Each valid request makes exactly two downstream accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bridge idle; the request is taken when both are high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_link | input | 1 | Link window select |
| req_bdf | input | 16 | Bus [15:8], device [7:3], function [2:0] |
| req_offset | input | 16 | Configuration register byte offset |
| req_size | input | 3 | Access size in bytes |
| req_wdata | input | 32 | Write data, right-aligned |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read data, right-aligned |
| rsp_status | output | 2 | 00 ok, 01 parameter error |
| mem_valid | output | 1 | Downstream access offered |
| mem_ready | input | 1 | Downstream access taken |
| mem_write | output | 1 | Downstream access is a write |
| mem_wide | output | 1 | 1 = 64-bit address word, 0 = 32-bit data access |
| mem_addr | output | 64 | Downstream byte address |
| mem_wdata | output | 64 | Downstream write data (data access uses [31:0]) |
| mem_be | output | 8 | Downstream byte enables |
| mem_rsp_valid | input | 1 | Downstream access completed |
| mem_rsp_data | input | 32 | Downstream read data |

## Verification
The bench sweeps both links, all eight size codes, and offsets that cover every byte position in the first two words, the last word below the 0xFFF limit and two offsets past it. Each point is written and then read back. The sweep separates the three rejection causes from one another and from legal accesses. Byte writes at shifting positions, followed by half-word and word reads of the same words, distinguish a correct little-endian lane placement from a swapped or unshifted one. Varying the bus/device/function values and using two windows shows a misplaced field in the address word or a wrong window base. A responder that stalls now and then exposes a data access issued before the address write completes.

// File: rtl/cfg_bridge_pkg.sv
package cfg_bridge_pkg;

    localparam int unsigned WORD_BITS  = 64;
    localparam int unsigned CFG_DATA_W = 32;
    localparam int unsigned BUS_W      = 8;
    localparam int unsigned DEV_W      = 5;
    localparam int unsigned FN_W       = 3;
    localparam int unsigned BDF_W      = BUS_W + DEV_W + FN_W;

    // field starts in MSB-first numbering of the address word
    localparam int unsigned FLD_EN   = 0;
    localparam int unsigned FLD_BUS  = 4;
    localparam int unsigned FLD_DEV  = 12;
    localparam int unsigned FLD_FN   = 17;
    localparam int unsigned FLD_REG  = 20;

    typedef enum logic [1:0] {
        STAT_OK    = 2'b00,
        STAT_PARAM = 2'b01
    } cfg_status_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR_REQ,
        S_ADDR_WAIT,
        S_DATA_REQ,
        S_DATA_WAIT,
        S_DONE
    } bridge_state_e;

    // all ones in the width selected by a size code; invalid codes give full width
    function automatic logic [CFG_DATA_W-1:0] width_ones(input logic [2:0] size);
        logic [CFG_DATA_W-1:0] m;
        unique case (size)
            3'd1:    m = CFG_DATA_W'(8'hFF);
            3'd2:    m = CFG_DATA_W'(16'hFFFF);
            default: m = '1;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/cfg_req_check.sv
module cfg_req_check
    import cfg_bridge_pkg::*;
#(
    parameter int unsigned OFS_W    = 16,
    parameter int unsigned REG_SPAN = 4096
) (
    input  logic [OFS_W-1:0]      ofs,
    input  logic [2:0]            size,
    output logic                  req_ok,
    output logic [CFG_DATA_W-1:0] reject_data
);
    logic size_ok;
    logic range_ok;
    logic align_ok;

    always_comb begin
        size_ok  = (size == 3'd1) || (size == 3'd2) || (size == 3'd4);
        range_ok = (ofs < OFS_W'(REG_SPAN));
        unique case (size)
            3'd2:    align_ok = (ofs[0] == 1'b0);
            3'd4:    align_ok = (ofs[1:0] == 2'b00);
            default: align_ok = 1'b1;
        endcase
        req_ok      = size_ok && range_ok && align_ok;
        reject_data = width_ones(size);
    end

endmodule

// File: rtl/cfg_addr_pack.sv
module cfg_addr_pack
    import cfg_bridge_pkg::*;
#(
    parameter int unsigned REG_W = 12
) (
    input  logic [BDF_W-1:0]     bdf,
    input  logic [REG_W-1:0]     reg_ofs,
    output logic [WORD_BITS-1:0] word
);
    localparam int unsigned IX_EN  = WORD_BITS - 1 - FLD_EN;
    localparam int unsigned IX_BUS = WORD_BITS - 1 - FLD_BUS;
    localparam int unsigned IX_DEV = WORD_BITS - 1 - FLD_DEV;
    localparam int unsigned IX_FN  = WORD_BITS - 1 - FLD_FN;
    localparam int unsigned IX_REG = WORD_BITS - 1 - FLD_REG;

    logic [BUS_W-1:0] bus_num;
    logic [DEV_W-1:0] dev_num;
    logic [FN_W-1:0]  fn_num;

    assign bus_num = bdf[BDF_W-1 -: BUS_W];
    assign dev_num = bdf[FN_W +: DEV_W];
    assign fn_num  = bdf[FN_W-1:0];

    always_comb begin
        word                     = '0;
        word[IX_EN]              = 1'b1;
        word[IX_BUS -: BUS_W]    = bus_num;
        word[IX_DEV -: DEV_W]    = dev_num;
        word[IX_FN  -: FN_W]     = fn_num;
        word[IX_REG -: REG_W]    = {reg_ofs[REG_W-1:2], 2'b00};
    end

endmodule

// File: rtl/cfg_lane_map.sv
module cfg_lane_map
    import cfg_bridge_pkg::*;
#(
    parameter int unsigned DATA_W = CFG_DATA_W,
    localparam int unsigned BE_W   = DATA_W / 8,
    localparam int unsigned LANE_W = $clog2(BE_W)
) (
    input  logic [2:0]        size,
    input  logic [LANE_W-1:0] lane_sel,
    input  logic [DATA_W-1:0] wdata_in,
    input  logic [DATA_W-1:0] rdata_in,
    output logic [BE_W-1:0]   be,
    output logic [DATA_W-1:0] wdata_out,
    output logic [DATA_W-1:0] rdata_out
);
    logic [LANE_W-1:0]   lane;
    logic [LANE_W+2:0]   shift;
    logic [BE_W-1:0]     be_base;
    logic [DATA_W-1:0]   mask;

    always_comb begin
        unique case (size)
            3'd1: begin
                lane    = lane_sel;
                be_base = BE_W'(1);
            end
            3'd2: begin
                lane    = {lane_sel[LANE_W-1:1], 1'b0};
                be_base = BE_W'(3);
            end
            default: begin
                lane    = '0;
                be_base = '1;
            end
        endcase
        mask      = DATA_W'(width_ones(size));
        shift     = {lane, 3'b000};
        be        = be_base << lane;
        wdata_out = (wdata_in & mask) << shift;
        rdata_out = (rdata_in >> shift) & mask;
    end

endmodule

// File: rtl/cfg_window_bridge.sv
module cfg_window_bridge
    import cfg_bridge_pkg::*;
#(
    parameter logic [WORD_BITS-1:0] BASE_ADDR     = 64'h0000_0006_0300_0000,
    parameter int unsigned          NUM_LINKS     = 2,
    parameter int unsigned          LINK_STRIDE   = 256,
    parameter int unsigned          DATA_PORT_OFS = 128,
    parameter int unsigned          OFS_W         = 16,
    parameter int unsigned          REG_SPAN      = 4096,
    localparam int unsigned LINK_W   = (NUM_LINKS > 1) ? $clog2(NUM_LINKS) : 1,
    localparam int unsigned REG_W    = $clog2(REG_SPAN),
    localparam int unsigned BE_W     = CFG_DATA_W / 8,
    localparam int unsigned LANE_W   = $clog2(BE_W),
    localparam int unsigned MEM_BE_W = WORD_BITS / 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic                    req_write,
    input  logic [LINK_W-1:0]       req_link,
    input  logic [BDF_W-1:0]        req_bdf,
    input  logic [OFS_W-1:0]        req_offset,
    input  logic [2:0]              req_size,
    input  logic [CFG_DATA_W-1:0]   req_wdata,
    output logic                    rsp_done,
    output logic [CFG_DATA_W-1:0]   rsp_rdata,
    output logic [1:0]              rsp_status,
    output logic                    mem_valid,
    input  logic                    mem_ready,
    output logic                    mem_write,
    output logic                    mem_wide,
    output logic [WORD_BITS-1:0]    mem_addr,
    output logic [WORD_BITS-1:0]    mem_wdata,
    output logic [MEM_BE_W-1:0]     mem_be,
    input  logic                    mem_rsp_valid,
    input  logic [CFG_DATA_W-1:0]   mem_rsp_data
);

    bridge_state_e state_q, state_d;

    logic                  r_wr;
    logic [LINK_W-1:0]     r_link;
    logic [BDF_W-1:0]      r_bdf;
    logic [REG_W-1:0]      r_reg;
    logic [2:0]            r_size;
    logic [CFG_DATA_W-1:0] r_wdata;
    logic [CFG_DATA_W-1:0] rdata_q;
    cfg_status_e           status_q;

    logic                  accept;
    logic                  chk_ok;
    logic [CFG_DATA_W-1:0] chk_reject_data;
    logic [WORD_BITS-1:0]  addr_word;
    logic [BE_W-1:0]       lane_be;
    logic [CFG_DATA_W-1:0] lane_wdata;
    logic [CFG_DATA_W-1:0] lane_rdata;
    logic [WORD_BITS-1:0]  win_base;
    logic [WORD_BITS-1:0]  win_tbl [NUM_LINKS];

    // one window base per link
    for (genvar g = 0; g < NUM_LINKS; g++) begin : g_win
        assign win_tbl[g] = BASE_ADDR + WORD_BITS'(g) * WORD_BITS'(LINK_STRIDE);
    end

    assign win_base = win_tbl[r_link];
    assign accept   = req_valid && (state_q == S_IDLE);

    cfg_req_check #(
        .OFS_W    (OFS_W),
        .REG_SPAN (REG_SPAN)
    ) u_check (
        .ofs         (req_offset),
        .size        (req_size),
        .req_ok      (chk_ok),
        .reject_data (chk_reject_data)
    );

    cfg_addr_pack #(
        .REG_W (REG_W)
    ) u_pack (
        .bdf     (r_bdf),
        .reg_ofs (r_reg),
        .word    (addr_word)
    );

    cfg_lane_map #(
        .DATA_W (CFG_DATA_W)
    ) u_lanes (
        .size      (r_size),
        .lane_sel  (r_reg[LANE_W-1:0]),
        .wdata_in  (r_wdata),
        .rdata_in  (mem_rsp_data),
        .be        (lane_be),
        .wdata_out (lane_wdata),
        .rdata_out (lane_rdata)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (accept) begin
                    state_d = chk_ok ? S_ADDR_REQ : S_DONE;
                end
            end
            S_ADDR_REQ: begin
                if (mem_ready) state_d = S_ADDR_WAIT;
            end
            S_ADDR_WAIT: begin
                if (mem_rsp_valid) state_d = S_DATA_REQ;
            end
            S_DATA_REQ: begin
                if (mem_ready) state_d = S_DATA_WAIT;
            end
            S_DATA_WAIT: begin
                if (mem_rsp_valid) state_d = S_DONE;
            end
            S_DONE: begin
                state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // request capture and response data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_wr     <= 1'b0;
            r_link   <= '0;
            r_bdf    <= '0;
            r_reg    <= '0;
            r_size   <= '0;
            r_wdata  <= '0;
            rdata_q  <= '0;
            status_q <= STAT_OK;
        end else begin
            if (accept) begin
                r_wr    <= req_write;
                r_link  <= req_link;
                r_bdf   <= req_bdf;
                r_reg   <= req_offset[REG_W-1:0];
                r_size  <= req_size;
                r_wdata <= req_wdata;
                if (chk_ok) begin
                    rdata_q  <= '0;
                    status_q <= STAT_OK;
                end else begin
                    rdata_q  <= chk_reject_data;
                    status_q <= STAT_PARAM;
                end
            end
            if ((state_q == S_DATA_WAIT) && mem_rsp_valid && !r_wr) begin
                rdata_q <= lane_rdata;
            end
        end
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        rsp_done  = 1'b0;
        mem_valid = 1'b0;
        mem_write = 1'b0;
        mem_wide  = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        mem_be    = '0;
        unique case (state_q)
            S_IDLE: begin
                req_ready = 1'b1;
            end
            S_ADDR_REQ: begin
                mem_valid = 1'b1;
                mem_write = 1'b1;
                mem_wide  = 1'b1;
                mem_addr  = win_base;
                mem_wdata = addr_word;
                mem_be    = '1;
            end
            S_DATA_REQ: begin
                mem_valid = 1'b1;
                mem_write = r_wr;
                mem_addr  = win_base + WORD_BITS'(DATA_PORT_OFS);
                mem_wdata = WORD_BITS'(lane_wdata);
                mem_be    = MEM_BE_W'(lane_be);
            end
            S_DONE: begin
                rsp_done = 1'b1;
            end
            default: begin
            end
        endcase
    end

    assign rsp_rdata  = rdata_q;
    assign rsp_status = status_q;

endmodule

// File: rtl/cfg_window_bridge_chk.sv
module cfg_window_bridge_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_ready,
    input logic       rsp_done,
    input logic [1:0] rsp_status,
    input logic [7:0] rdata_lo,
    input logic       mem_valid,
    input logic       mem_ready,
    input logic       mem_wide,
    input logic [1:0] addr_lo,
    input logic       word_msb,
    input logic [7:0] mem_be,
    input logic       mem_rsp_valid
);
    logic wide_pending;
    logic addr_acked;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wide_pending <= 1'b0;
            addr_acked   <= 1'b0;
        end else begin
            if (mem_valid && mem_ready && mem_wide) begin
                wide_pending <= 1'b1;
            end else if (mem_rsp_valid && wide_pending) begin
                wide_pending <= 1'b0;
                addr_acked   <= 1'b1;
            end
            if (rsp_done) begin
                addr_acked <= 1'b0;
            end
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done); // R10

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> !req_ready); // R10

    AST_OFFER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_wide) && $stable(mem_be))); // R7

    AST_ADDR_WORD_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_wide) |-> (word_msb && (mem_be == 8'hFF))); // R5

    AST_LANE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_wide) |-> ((mem_be[7:4] == 4'b0000) &&
            (($countones(mem_be) == 1) || ($countones(mem_be) == 2) || ($countones(mem_be) == 4)))); // R7

    AST_DATA_AFTER_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_wide) |-> (addr_acked && !wide_pending)); // R8

    AST_REJECT_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && (rsp_status == 2'b01)) |-> (rdata_lo == 8'hFF)); // R4

    AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (addr_lo == 2'b00)); // R6

endmodule

bind cfg_window_bridge cfg_window_bridge_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_ready     (req_ready),
    .rsp_done      (rsp_done),
    .rsp_status    (rsp_status),
    .rdata_lo      (rsp_rdata[7:0]),
    .mem_valid     (mem_valid),
    .mem_ready     (mem_ready),
    .mem_wide      (mem_wide),
    .addr_lo       (mem_addr[1:0]),
    .word_msb      (mem_wdata[63]),
    .mem_be        (mem_be),
    .mem_rsp_valid (mem_rsp_valid)
);

// File: tb/cfg_window_bridge_test.sv
`timescale 1ns/1ps
module cfg_window_bridge_test;

    localparam logic [63:0] BASE = 64'h0000_0006_0300_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [0:0]  req_link = '0;
    logic [15:0] req_bdf = '0;
    logic [15:0] req_offset = '0;
    logic [2:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_done;
    logic [31:0] rsp_rdata;
    logic [1:0]  rsp_status;
    logic        mem_valid;
    logic        mem_ready = 1'b0;
    logic        mem_write;
    logic        mem_wide;
    logic [63:0] mem_addr;
    logic [63:0] mem_wdata;
    logic [7:0]  mem_be;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    cfg_window_bridge #(.BASE_ADDR(BASE)) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_link(req_link), .req_bdf(req_bdf), .req_offset(req_offset),
        .req_size(req_size), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .rsp_status(rsp_status),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
        .mem_wide(mem_wide), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_be(mem_be), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    // downstream responder and access log
    logic [7:0]  dev_mem [2][4096];
    logic [11:0] lat_reg [2];
    logic [63:0] rel_a;
    logic        rel_lk;
    int          log_n = 0;
    int          rsp_seen = 0;
    logic [63:0] log_addr [4];
    logic [63:0] log_wdata [4];
    logic [7:0]  log_be [4];
    logic        log_wide [4];
    logic        log_write [4];
    int          log_seen [4];
    logic [3:0]  stall_cnt = '0;

    initial begin
        for (int l = 0; l < 2; l++) begin
            lat_reg[l] = '0;
            for (int i = 0; i < 4096; i++) dev_mem[l][i] = 8'h00;
        end
    end

    always @(posedge clk) begin
        stall_cnt     <= stall_cnt + 4'd1;
        mem_ready     <= (stall_cnt[1:0] != 2'b11);
        mem_rsp_valid <= 1'b0;
        if (rst_n && mem_valid && mem_ready) begin
            if (log_n < 4) begin
                log_addr[log_n]  = mem_addr;
                log_wdata[log_n] = mem_wdata;
                log_be[log_n]    = mem_be;
                log_wide[log_n]  = mem_wide;
                log_write[log_n] = mem_write;
                log_seen[log_n]  = rsp_seen;
            end
            log_n = log_n + 1;
            rel_a  = mem_addr - BASE;
            rel_lk = rel_a[8];
            if (mem_wide) begin
                lat_reg[rel_lk] <= mem_wdata[43:32];
            end else if (mem_write) begin
                for (int b = 0; b < 4; b++)
                    if (mem_be[b]) dev_mem[rel_lk][{lat_reg[rel_lk][11:2], 2'(b)}] <= mem_wdata[8*b +: 8];
            end else begin
                mem_rsp_data <= {dev_mem[rel_lk][{lat_reg[rel_lk][11:2], 2'd3}],
                                 dev_mem[rel_lk][{lat_reg[rel_lk][11:2], 2'd2}],
                                 dev_mem[rel_lk][{lat_reg[rel_lk][11:2], 2'd1}],
                                 dev_mem[rel_lk][{lat_reg[rel_lk][11:2], 2'd0}]};
            end
            mem_rsp_valid <= 1'b1;
        end
        if (mem_rsp_valid) rsp_seen = rsp_seen + 1;
    end

    // bench shadow of configuration space
    logic [7:0] shadow [2][4096];

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_word(input logic [15:0] bdf, input logic [15:0] ofs);
        logic [63:0] w;
        w = 64'h1 << 63;
        w = w | (64'(bdf[15:8]) << 52);
        w = w | (64'(bdf[7:3]) << 47);
        w = w | (64'(bdf[2:0]) << 44);
        w = w | (64'(ofs[11:2]) << 34);
        return w;
    endfunction

    task automatic run_req(input bit wr, input bit lk, input logic [15:0] bdf,
                           input logic [15:0] ofs, input logic [2:0] sz, input logic [31:0] wd);
        bit          size_ok, align_ok, range_ok, valid;
        logic [31:0] ones, exp_rd, exp_lane_wd;
        logic [7:0]  exp_be;
        logic [63:0] win;
        int          waited;
        string       rtag;
        size_ok  = (sz == 3'd1) || (sz == 3'd2) || (sz == 3'd4);
        range_ok = (ofs <= 16'h0FFF);
        align_ok = size_ok ? ((ofs % 16'(sz)) == 0) : 1'b1;
        valid    = size_ok && range_ok && align_ok;
        ones     = (sz == 3'd1) ? 32'hFF : (sz == 3'd2) ? 32'hFFFF : 32'hFFFF_FFFF;
        rtag     = !size_ok ? "R3" : !range_ok ? "R1" : !align_ok ? "R2" : "R4";
        win      = BASE + 64'(lk) * 64'd256;

        @(negedge clk);
        log_n      = 0;
        rsp_seen   = 0;
        req_valid  = 1'b1;
        req_write  = wr;
        req_link   = lk;
        req_bdf    = bdf;
        req_offset = ofs;
        req_size   = sz;
        req_wdata  = wd;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R10 ready low while busy", 64'(req_ready), 64'd0);
        waited = 0;
        while (!rsp_done && waited < 200) begin
            @(negedge clk);
            waited++;
        end
        chk(rsp_done == 1'b1, "R10 done pulse seen", 64'(rsp_done), 64'd1);

        chk(rsp_status == (valid ? 2'b00 : 2'b01), $sformatf("%s status", rtag),
            64'(rsp_status), valid ? 64'd0 : 64'd1);
        chk(log_n == (valid ? 2 : 0), $sformatf("%s R10 downstream access count", rtag),
            64'(log_n), valid ? 64'd2 : 64'd0);

        if (!valid) begin
            chk(rsp_rdata == ones, "R4 reject data", 64'(rsp_rdata), 64'(ones));
        end else begin
            exp_be      = 8'(((32'd1 << sz) - 32'd1) << ofs[1:0]);
            exp_lane_wd = (wd & ones) << (8 * ofs[1:0]);
            chk(log_wide[0] && log_write[0] && log_be[0] == 8'hFF, "R6 address write shape",
                {log_wide[0], log_write[0], log_be[0]}, {1'b1, 1'b1, 8'hFF});
            chk(log_addr[0] == win, "R6 address write target", log_addr[0], win);
            chk(log_wdata[0] == exp_word(bdf, ofs), "R5 address word", log_wdata[0], exp_word(bdf, ofs));
            chk(!log_wide[1] && log_write[1] == wr, "R7 data access kind",
                {log_wide[1], log_write[1]}, {1'b0, wr});
            chk(log_addr[1] == win + 64'd128, "R7 data port address", log_addr[1], win + 64'd128);
            chk(log_be[1] == exp_be, "R7 byte enables", 64'(log_be[1]), 64'(exp_be));
            chk(log_seen[1] >= 1, "R8 address response before data", 64'(log_seen[1]), 64'd1);
            if (wr) begin
                chk(log_wdata[1][31:0] == exp_lane_wd, "R7 write lanes",
                    64'(log_wdata[1][31:0]), 64'(exp_lane_wd));
                chk(rsp_rdata == 32'd0, "R4 write data zero", 64'(rsp_rdata), 64'd0);
                for (int i = 0; i < 4; i++)
                    if (i < int'(sz)) shadow[lk][ofs[11:0] + 12'(i)] = wd[8*i +: 8];
            end else begin
                exp_rd = '0;
                for (int i = 0; i < 4; i++)
                    if (i < int'(sz)) exp_rd = exp_rd | (32'(shadow[lk][ofs[11:0] + 12'(i)]) << (8 * i));
                chk(rsp_rdata == exp_rd, "R9 read data", 64'(rsp_rdata), 64'(exp_rd));
            end
        end
        @(negedge clk);
        chk(rsp_done == 1'b0 && req_ready == 1'b1, "R10 back to idle",
            {rsp_done, req_ready}, {1'b0, 1'b1});
    endtask

    logic [15:0] ofs_list [14];

    initial begin
        ofs_list = '{16'h000, 16'h001, 16'h002, 16'h003, 16'h004, 16'h005, 16'h006, 16'h007,
                     16'hFFC, 16'hFFD, 16'hFFE, 16'hFFF, 16'h1000, 16'h8004};
        for (int l = 0; l < 2; l++)
            for (int i = 0; i < 4096; i++) shadow[l][i] = 8'h00;
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1 && rsp_done == 1'b0 && mem_valid == 1'b0, "R10 reset state",
            {req_ready, rsp_done, mem_valid}, {1'b1, 1'b0, 1'b0});
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(req_ready == 1'b1 && mem_valid == 1'b0, "R10 idle after reset",
            {req_ready, mem_valid}, {1'b1, 1'b0});

        for (int lk = 0; lk < 2; lk++) begin
            for (int sz = 0; sz < 8; sz++) begin
                for (int k = 0; k < 14; k++) begin
                    logic [15:0] bdf;
                    logic [31:0] wd;
                    bdf = 16'(k * 4933 + sz * 211 + lk * 30011);
                    wd  = 32'hC3A5_0000 ^ (32'(ofs_list[k]) * 32'h0101_0101) ^ 32'(sz << 12) ^ 32'(lk << 27);
                    run_req(1'b1, 1'(lk), bdf, ofs_list[k], 3'(sz), wd);
                    run_req(1'b0, 1'(lk), ~bdf, ofs_list[k], 3'(sz), 32'hDEAD_BEEF);
                end
            end
            for (int k = 0; k < 2; k++)
                run_req(1'b0, 1'(lk), 16'h5A5A, 16'(4 * k), 3'd4, 32'h0);
            run_req(1'b0, 1'(lk), 16'hA5A5, 16'hFFC, 3'd4, 32'h0);
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule